// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of small perceptrons. Each entry is a vector of signed integer weights: one bias weight and one weight for each bit of a global outcome history. A lookup hashes the branch address to a table entry. In the same cycle it returns the entry index, the current history, the signed perceptron output and a one-bit direction guess. The output is a dot product in which every history bit counts as +1 (taken) or -1 (not taken). It is formed by adding or subtracting each weight, so no multiplier is needed.

When the branch resolves, the caller sends back the outcome together with the index, the history snapshot and the output it received at lookup time. The block retrains that entry only when the guess was wrong or the output magnitude was small. The trained weights are written back to the same entry, and the resolved outcome is shifted into the history. The table costs storage linear in the history length, so long histories remain affordable. The threshold and the weight width are derived from the history length when the block is elaborated; both can be overridden.

Top module: `branch_perceptron`

## Requirements
- R1: `lk_index` equals (`lk_addr[IDX_W-1:0]` XOR `lk_addr[2*IDX_W-1:IDX_W]`) modulo DEPTH, where IDX_W = clog2(DEPTH).
- R2: `lk_sum` equals the bias weight of the selected entry plus, for i = 1..HIST_LEN, weight i when `lk_hist[i-1]` is 1 or minus weight i when it is 0. `lk_hist` is the current history register, and bit 0 is the newest outcome.
- R3: `lk_taken` is 1 exactly when `lk_sum` is zero or positive (two's complement sign bit clear).
- R4: An update with `up_valid`=1 retrains entry `up_index` only when (`up_sum` >= 0) differs from `up_taken` or |`up_sum`| <= THETA. Otherwise every weight of that entry keeps its value.
- R5: When retraining, the bias weight steps +1 if `up_taken`=1 and -1 if it is 0. Weight i steps +1 when `up_hist[i-1]` equals `up_taken` and -1 otherwise. All weights step in the same clock edge.
- R6: Weight steps saturate at 2^(WGT_W-1)-1 and -2^(WGT_W-1) and never wrap.
- R7: On every update the history shifts left by one, with `up_taken` entering bit 0. Without an update the history holds.
- R8: After reset, every weight and every history bit is zero, so every lookup returns sum 0 with `lk_taken`=1.
- R9: With default parameters THETA = floor(1.93*HIST_LEN + 14), which is 37 for HIST_LEN = 12, and WGT_W = 1 + clog2(THETA+1).
- R10: An update changes only entry `up_index`. The new weights and history are visible on the lookup port from the cycle after the update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | ADDR_W | Branch address to look up |
| lk_index | output | IDX_W | Table entry selected by the hash |
| lk_hist | output | HIST_LEN | Current history snapshot, bit 0 newest |
| lk_sum | output | SUM_W | Signed perceptron output |
| lk_taken | output | 1 | Direction guess, 1 = taken |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_index | input | IDX_W | Entry to retrain |
| up_hist | input | HIST_LEN | History snapshot captured at lookup |
| up_sum | input | SUM_W | Perceptron output captured at lookup |

## Verification
A small configuration (4 history bits, 4 entries, threshold 3, 3-bit weights) is swept through every 8-bit address to prove the hash and the cleared reset state. It is then driven with always-taken, never-taken, alternating and history-correlated outcome streams. The constant streams drive weights into both saturation limits. The alternating and correlated streams push weights in mixed directions and exercise sign mismatches. A sweep of every supplied output from -6 to +6 against both outcomes probes the threshold edge (3 versus 4) and the sign rule at zero, and after each step all four entries are read back to catch training that is missing, spurious or misdirected. A default-parameter instance tells apart outputs of 38 and 37, which pins the derived threshold.

// File: rtl/branch_perceptron.sv
module branch_perceptron #(
  parameter int ADDR_W   = 32,
  parameter int HIST_LEN = 12,
  parameter int DEPTH    = 16,
  parameter int THETA    = (193 * HIST_LEN + 1400) / 100,
  parameter int WGT_W    = 1 + $clog2(THETA + 1),
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SUM_W   = WGT_W + $clog2(HIST_LEN + 2) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       lk_addr,
  output logic [IDX_W-1:0]        lk_index,
  output logic [HIST_LEN-1:0]     lk_hist,
  output logic signed [SUM_W-1:0] lk_sum,
  output logic                    lk_taken,
  input  logic                    up_valid,
  input  logic                    up_taken,
  input  logic [IDX_W-1:0]        up_index,
  input  logic [HIST_LEN-1:0]     up_hist,
  input  logic signed [SUM_W-1:0] up_sum
);

  localparam int NW = HIST_LEN + 1;
  localparam logic signed [WGT_W-1:0] WMAX = {1'b0, {(WGT_W-1){1'b1}}};
  localparam logic signed [WGT_W-1:0] WMIN = {1'b1, {(WGT_W-1){1'b0}}};
  localparam logic signed [SUM_W:0]   THETA_V = (SUM_W+1)'(THETA);

  logic signed [WGT_W-1:0] tbl [DEPTH][NW];
  logic [HIST_LEN-1:0]     ghr;

  logic [IDX_W-1:0] h_lo, h_hi;
  assign h_lo     = lk_addr[IDX_W-1:0];
  assign h_hi     = lk_addr[2*IDX_W-1:IDX_W];
  assign lk_index = IDX_W'({1'b0, h_lo ^ h_hi} % (IDX_W+1)'(DEPTH));
  assign lk_hist  = ghr;

  logic signed [SUM_W-1:0] acc;
  always_comb begin
    acc = SUM_W'(tbl[lk_index][0]);
    for (int i = 1; i < NW; i++) begin
      if (ghr[i-1]) acc = acc + SUM_W'(tbl[lk_index][i]);
      else          acc = acc - SUM_W'(tbl[lk_index][i]);
    end
  end
  assign lk_sum   = acc;
  assign lk_taken = ~acc[SUM_W-1];

  logic                  up_pred;
  logic signed [SUM_W:0] up_ext, up_mag;
  logic                  do_train;
  assign up_pred  = ~up_sum[SUM_W-1];
  assign up_ext   = {up_sum[SUM_W-1], up_sum};
  assign up_mag   = up_sum[SUM_W-1] ? -up_ext : up_ext;
  assign do_train = up_valid && ((up_pred != up_taken) || (up_mag <= THETA_V));

  function automatic logic signed [WGT_W-1:0] nudge(input logic signed [WGT_W-1:0] w,
                                                    input logic inc);
    if (inc) return (w == WMAX) ? w : w + WGT_W'(1);
    else     return (w == WMIN) ? w : w - WGT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghr <= '0;
      for (int e = 0; e < DEPTH; e++)
        for (int i = 0; i < NW; i++)
          tbl[e][i] <= '0;
    end else begin
      if (up_valid) ghr <= {ghr[HIST_LEN-2:0], up_taken};
      if (do_train) begin
        tbl[up_index][0] <= nudge(tbl[up_index][0], up_taken);
        for (int i = 1; i < NW; i++)
          tbl[up_index][i] <= nudge(tbl[up_index][i], up_hist[i-1] == up_taken);
      end
    end
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (lk_hist[0] == $past(up_taken)) && (lk_hist[HIST_LEN-1:1] == $past(lk_hist[HIST_LEN-2:0]))); // R7
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(lk_hist)); // R7
  AST_IDLE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!up_valid) && $stable(lk_addr)) |-> $stable(lk_sum)); // R10
  AST_PRED_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> (lk_sum >= 0)); // R3

  for (genvar e = 0; e < DEPTH; e++) begin : g_chk_e
    for (genvar i = 0; i < NW; i++) begin : g_chk_w
      AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(tbl[e][i]) - int'($past(tbl[e][i])) <= 1) &&
         (int'(tbl[e][i]) - int'($past(tbl[e][i])) >= -1))); // R6
      AST_OTHER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_valid || (int'(up_index) != e)) |=> $stable(tbl[e][i])); // R10
    end
  end

endmodule

// File: tb/branch_perceptron_tb.sv
module branch_perceptron_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // small instance: HIST_LEN 4, DEPTH 4, THETA 3, 3-bit weights
  logic [7:0]        s_addr = '0;
  logic [1:0]        s_idx;
  logic [3:0]        s_hist;
  logic signed [6:0] s_sum;
  logic              s_taken;
  logic              s_uv = 0, s_ut = 0;
  logic [1:0]        s_ui = '0;
  logic [3:0]        s_uh = '0;
  logic signed [6:0] s_us = '0;

  branch_perceptron #(.ADDR_W(8), .HIST_LEN(4), .DEPTH(4), .THETA(3), .WGT_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_addr(s_addr), .lk_index(s_idx), .lk_hist(s_hist),
    .lk_sum(s_sum), .lk_taken(s_taken), .up_valid(s_uv), .up_taken(s_ut),
    .up_index(s_ui), .up_hist(s_uh), .up_sum(s_us));

  // default instance
  logic [31:0]        d_addr = '0;
  logic [3:0]         d_idx;
  logic [11:0]        d_hist;
  logic signed [11:0] d_sum;
  logic               d_taken;
  logic               d_uv = 0, d_ut = 0;
  logic [3:0]         d_ui = '0;
  logic [11:0]        d_uh = '0;
  logic signed [11:0] d_us = '0;

  branch_perceptron u_dut_def (
    .clk(clk), .rst_n(rst_n), .lk_addr(d_addr), .lk_index(d_idx), .lk_hist(d_hist),
    .lk_sum(d_sum), .lk_taken(d_taken), .up_valid(d_uv), .up_taken(d_ut),
    .up_index(d_ui), .up_hist(d_uh), .up_sum(d_us));

  int mw [4][5];
  logic [3:0] mh;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_idx(input logic [7:0] a);
    return int'(a[1:0] ^ a[3:2]) % 4;
  endfunction

  function automatic int exp_sum(input int e);
    int s = mw[e][0];
    for (int i = 1; i < 5; i++) s += mh[i-1] ? mw[e][i] : -mw[e][i];
    return s;
  endfunction

  task automatic look(input logic [7:0] a);
    int e, s;
    s_addr = a;
    #2;
    e = exp_idx(a);
    s = exp_sum(e);
    chk(int'(s_idx) == e, "R1 index", int'(s_idx), e);
    chk(int'(s_sum) == s, "R2 sum", int'(s_sum), s);
    chk(s_taken == (s >= 0), "R3 taken", int'(s_taken), int'(s >= 0));
    chk(s_hist == mh, "R7 history", int'(s_hist), int'(mh));
  endtask

  function automatic int clampw(input int v);
    return (v > 3) ? 3 : (v < -4) ? -4 : v;
  endfunction

  task automatic upd(input int e, input bit t, input logic [3:0] h, input int s);
    bit tr;
    @(negedge clk);
    s_uv = 1; s_ut = t; s_ui = 2'(e); s_uh = h; s_us = 7'(s);
    @(posedge clk);
    #1 s_uv = 0;
    tr = ((s >= 0) != t) || (((s < 0) ? -s : s) <= 3);   // R4
    if (tr) begin
      mw[e][0] = clampw(mw[e][0] + (t ? 1 : -1));          // R5 R6
      for (int i = 1; i < 5; i++) mw[e][i] = clampw(mw[e][i] + ((h[i-1] == t) ? 1 : -1));
    end
    mh = {mh[2:0], t};
  endtask

  task automatic dupd(input bit t, input int s);
    @(negedge clk);
    d_uv = 1; d_ut = t; d_ui = '0; d_uh = '0; d_us = 12'(s);
    @(posedge clk);
    #1 d_uv = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int e = 0; e < 4; e++) for (int i = 0; i < 5; i++) mw[e][i] = 0;
    mh = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R8: cleared state, R1 exhaustive address sweep
    for (int a = 0; a < 256; a++) look(8'(a));
    chk(s_taken == 1'b1, "R8 reset taken", int'(s_taken), 1);

    // R9: default threshold 37; 38 with agreeing sign must not train
    d_addr = '0;
    dupd(1, 38);
    #2;
    chk(d_sum == 0, "R9 no train at 38", int'(d_sum), 0);
    chk(d_hist == 12'h001, "R9 history", int'(d_hist), 1);
    dupd(1, 37);
    #2;
    chk(d_sum == 9, "R9 train at 37", int'(d_sum), 9);
    chk(d_hist == 12'h003, "R9 history", int'(d_hist), 3);

    // R4 R5 R6 R10: outcome streams
    lf = 16'hACE1;
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 300; n++) begin
        int e, s;
        bit t;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        look(lf[7:0]);
        e = exp_idx(lf[7:0]);
        s = exp_sum(e);
        case (p)
          0: t = 1;
          1: t = 0;
          2: t = n[0];
          default: t = mh[1];
        endcase
        upd(e, t, mh, s);
      end
    end

    // R4 threshold/sign sweep, R10 every entry read back
    for (int s = -6; s <= 6; s++) begin
      for (int t = 0; t < 2; t++) begin
        upd((s + 6) % 4, t[0], 4'(s + 6), s);
        for (int j = 0; j < 4; j++) look(8'(j));
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule